// File: doc/BRIEF.md
# Timer Counter with Dual Capture

This block is a free-running 16-bit up-counter with two capture registers and one compare register. A mode register picks what advances the counter: rising edges on an external pin, or one of three ticks taken from a prescaler on the system clock. The same register turns on clear-on-compare and picks which events copy the count into the capture registers. Software can also take a capture into the first capture register by writing the mode register.

Capture events come from two external pins and from a trigger input that is normally driven by another timer's output. Every asynchronous input passes through a two-flop synchronizer and then an edge detector. Registers are reached over a small synchronous bus. A read returns its data one cycle after the request, marked by a valid strobe.

Top module: `cap_timer`

## Requirements
- R1: After reset the mode register, compare register, both capture registers and the counter all read 0.
- R2: Bus addresses are 0 mode, 1 compare, 2 capture A, 3 capture B, 4 count. Read data and `rd_valid` appear the cycle after `rd_en`. Mode bits [7:5] always read 0, and bits [4:0] read back as written.
- R3: Mode bits [1:0] pick the count source: 00 counts synchronized rising edges of `pin_a`; 01, 10 and 11 give one tick every 2, 8 and 32 system clocks.
- R4: On each tick the counter rises by one, and with clear disabled it wraps from 0xFFFF to 0. Without a tick it holds.
- R5: With mode bit 2 set, a tick taken while the count equals the compare register loads 0, so the count period is compare+1 ticks.
- R6: Capture mode bits [4:3] = 00 block every hardware capture.
- R7: Capture mode 01 loads capture A on a rising edge of `pin_a` and capture B on a rising edge of `pin_b`.
- R8: Capture mode 10 loads capture A on a rising edge of `pin_a` and capture B on a falling edge of `pin_a`.
- R9: Capture mode 11 loads capture A on a rising edge of `trig` and capture B on a falling edge of `trig`.
- R10: A mode write with bit 5 = 0 copies the count into capture A. With bit 5 = 1 the write takes no capture.
- R11: When a capture and a count increment fall in the same cycle, the captured value is the count from before the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, registered |
| rd_valid | output | 1 | rdata valid, one cycle after rd_en |
| pin_a | input | 1 | External count/capture pin |
| pin_b | input | 1 | External capture pin |
| trig | input | 1 | Capture trigger from another timer |

## Verification
On every cycle the assertions check the following:
- The prescaler ticks are nested, and the fastest tick never lasts two cycles.
- The counter holds when there is no tick, steps by one modulo 2^16 on a tick, and drops to zero on a tick that matches the compare register.
- Capture B never moves while hardware capture is off.
- Mode reads return zero in the upper bits.

Only the bench scenarios can show the rest:
- The actual division ratios, measured between two software captures.
- Which edge feeds which capture register in each mode.
- The pre-increment value seen when a `pin_a` edge both counts and captures.
- The compare+1 period.

// File: rtl/cap_timer.sv
module cap_timer #(
  parameter int CNT_W = 16,
  parameter int DIV_A_LOG = 1,
  parameter int DIV_B_LOG = 3,
  parameter int DIV_C_LOG = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             rd_valid,
  input  logic             pin_a,
  input  logic             pin_b,
  input  logic             trig
);
  localparam int PRE_W = DIV_C_LOG;

  logic [PRE_W-1:0] pre;
  logic [2:0]       sy_a, sy_b, sy_t;
  logic [1:0]       src_sel, cap_mode;
  logic             clr_en;
  logic [CNT_W-1:0] cnt, cmp, cap_a, cap_b;
  logic             tick;

  wire t_a = &pre[DIV_A_LOG-1:0];
  wire t_b = &pre[DIV_B_LOG-1:0];
  wire t_c = &pre[DIV_C_LOG-1:0];

  wire rise_a = sy_a[1] & ~sy_a[2];
  wire fall_a = ~sy_a[1] & sy_a[2];
  wire rise_b = sy_b[1] & ~sy_b[2];
  wire rise_t = sy_t[1] & ~sy_t[2];
  wire fall_t = ~sy_t[1] & sy_t[2];

  wire wr_mode = wr_en && addr == 3'd0;
  wire sw_cap  = wr_mode && !wdata[5];
  wire hit     = clr_en && cnt == cmp;

  always_comb begin
    case (src_sel)
      2'b00:   tick = rise_a;
      2'b01:   tick = t_a;
      2'b10:   tick = t_b;
      default: tick = t_c;
    endcase
  end

  wire ev_a = sw_cap
            | ((cap_mode == 2'b01 || cap_mode == 2'b10) & rise_a)
            | ((cap_mode == 2'b11) & rise_t);
  wire ev_b = ((cap_mode == 2'b01) & rise_b)
            | ((cap_mode == 2'b10) & fall_a)
            | ((cap_mode == 2'b11) & fall_t);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= '0;
      sy_a <= '0;
      sy_b <= '0;
      sy_t <= '0;
    end else begin
      pre  <= pre + 1'b1;
      sy_a <= {sy_a[1:0], pin_a};
      sy_b <= {sy_b[1:0], pin_b};
      sy_t <= {sy_t[1:0], trig};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_sel  <= 2'b00;
      clr_en   <= 1'b0;
      cap_mode <= 2'b00;
      cmp      <= '0;
    end else if (wr_en) begin
      if (addr == 3'd0) begin
        src_sel  <= wdata[1:0];
        clr_en   <= wdata[2];
        cap_mode <= wdata[4:3];
      end
      if (addr == 3'd1) cmp <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (tick) cnt <= hit ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a <= '0;
      cap_b <= '0;
    end else begin
      if (ev_a) cap_a <= cnt;
      if (ev_b) cap_b <= cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        case (addr)
          3'd0:    rdata <= {{(CNT_W-5){1'b0}}, cap_mode, clr_en, src_sel};
          3'd1:    rdata <= cmp;
          3'd2:    rdata <= cap_a;
          3'd3:    rdata <= cap_b;
          3'd4:    rdata <= cnt;
          default: rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             hit,
  input logic [CNT_W-1:0] cnt,
  input logic [1:0]       cap_mode,
  input logic [CNT_W-1:0] cap_b,
  input logic             t_a,
  input logic             t_b,
  input logic             t_c,
  input logic             rd_en,
  input logic [2:0]       addr,
  input logic [CNT_W-1:0] rdata
);
  a_r3_nested_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (t_c |-> t_b) and (t_b |-> t_a));

  a_r3_fast_tick_short: assert property (@(posedge clk) disable iff (!rst_n)
    t_a |=> !t_a);

  a_r4_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  a_r4_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hit) |=> cnt == $past(cnt) + 1'b1);

  a_r5_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hit) |=> cnt == '0);

  a_r6_cap_b_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode == 2'b00) |=> $stable(cap_b));

  a_r2_mode_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd0) |=> rdata[CNT_W-1:5] == '0);
endmodule

bind cap_timer cap_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .hit(hit), .cnt(cnt),
  .cap_mode(cap_mode), .cap_b(cap_b), .t_a(t_a), .t_b(t_b), .t_c(t_c),
  .rd_en(rd_en), .addr(addr), .rdata(rdata)
);

// File: tb/test_cap_timer.sv
`timescale 1ns/1ps
module test_cap_timer;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, wr_en, rd_en, rd_valid, pin_a, pin_b, trig;
  logic [2:0]  addr;
  logic [15:0] wdata, rdata;

  cap_timer i_cap_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .pin_a(pin_a), .pin_b(pin_b), .trig(trig)
  );

  typedef struct {
    logic [15:0] exp;
    bit          chk;
    bit          rel;
    string       tag;
  } item_t;

  item_t       q[$];
  item_t       it;
  logic [15:0] got;
  logic [15:0] last_val = '0;
  int n_chk = 0;
  int n_fail = 0;

  always @(negedge clk) begin
    if (rd_valid) begin
      if (q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2: unexpected read data %h, expected no response", rdata);
      end else begin
        it = q.pop_front();
        if (it.chk) begin
          got = it.rel ? rdata - last_val : rdata;
          n_chk++;
          if (got !== it.exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
          end
        end
        last_val = rdata;
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_push(input logic [2:0] a, input logic [15:0] e, input bit c, input bit r, input string t);
    item_t x;
    x.exp = e; x.chk = c; x.rel = r; x.tag = t;
    @(negedge clk); rd_en = 1'b1; addr = a; q.push_back(x);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] e, input string t);
    rd_push(a, e, 1'b1, 1'b0, t);
  endtask

  task automatic set_pin(input int which, input logic v);
    case (which)
      0: pin_a = v;
      1: pin_b = v;
      default: trig = v;
    endcase
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    set_pin(which, 1'b1);
    set_pin(which, 1'b0);
  endtask

  task automatic measure(input logic [1:0] src, input logic [15:0] e, input string t);
    wr(3'd0, {14'h0008, src});
    wr(3'd0, {14'h0000, src});
    rd_push(3'd2, '0, 1'b0, 1'b0, t);
    repeat (316) @(negedge clk);
    wr(3'd0, {14'h0000, src});
    rd_push(3'd2, e, 1'b1, 1'b1, t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    pin_a = 1'b0; pin_b = 1'b0; trig = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    rd(3'd0, 16'h0000, "R1 mode");
    rd(3'd1, 16'h0000, "R1 compare");
    rd(3'd2, 16'h0000, "R1 capture A");
    rd(3'd3, 16'h0000, "R1 capture B");
    rd(3'd4, 16'h0000, "R1 count");

    wr(3'd0, 16'h00FF);
    rd(3'd0, 16'h001F, "R2 mode readback");
    rd(3'd2, 16'h0000, "R10 bit5=1 no capture");
    wr(3'd0, 16'h0020);
    rd(3'd0, 16'h0000, "R2 mode cleared");

    pulse(0); pulse(0); pulse(1); pulse(2);
    rd(3'd4, 16'h0002, "R3 pin_a edges counted");
    rd(3'd2, 16'h0000, "R6 capture A idle");
    rd(3'd3, 16'h0000, "R6 capture B idle");
    wr(3'd0, 16'h0020);
    rd(3'd2, 16'h0000, "R10 bit5=1 write");
    wr(3'd0, 16'h0000);
    rd(3'd2, 16'h0002, "R10 software capture");

    wr(3'd0, 16'h0028);
    pulse(1);
    rd(3'd3, 16'h0002, "R7 pin_b rise to B");
    pulse(0);
    rd(3'd2, 16'h0002, "R7 R11 pin_a rise pre-increment");
    rd(3'd4, 16'h0003, "R4 count step");
    pulse(2);
    rd(3'd3, 16'h0002, "R7 trig ignored");

    wr(3'd0, 16'h0030);
    pulse(0);
    rd(3'd2, 16'h0003, "R8 rise to A");
    rd(3'd3, 16'h0004, "R8 fall to B");

    wr(3'd0, 16'h0038);
    set_pin(2, 1'b1);
    rd(3'd2, 16'h0004, "R9 trig rise to A");
    pulse(0);
    set_pin(2, 1'b0);
    rd(3'd3, 16'h0005, "R9 trig fall to B");
    pulse(1);
    rd(3'd3, 16'h0005, "R9 pin_b ignored");

    wr(3'd1, 16'h0007);
    wr(3'd0, 16'h0034);
    pulse(0);
    rd(3'd2, 16'h0005, "R5 A step1"); rd(3'd3, 16'h0006, "R5 B step1");
    pulse(0);
    rd(3'd2, 16'h0006, "R5 A step2"); rd(3'd3, 16'h0007, "R5 B step2");
    pulse(0);
    rd(3'd2, 16'h0007, "R5 A at match"); rd(3'd3, 16'h0000, "R5 cleared");
    pulse(0);
    rd(3'd2, 16'h0000, "R5 A restart"); rd(3'd3, 16'h0001, "R5 B restart");

    measure(2'b01, 16'd160, "R3 div2 rate");
    measure(2'b10, 16'd40,  "R3 div8 rate");
    measure(2'b11, 16'd10,  "R3 div32 rate");

    repeat (5) @(negedge clk);
    if (q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R2: %0d reads unanswered, expected 0", q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule